// File: doc/BRIEF.md
# SIMD Pairwise Widening Adder

This block performs a pairwise widening add over one packed integer vector. Each pair of neighbouring source elements is added. The sum is written into a result lane twice as wide as one source element, so the result holds half as many lanes as the source has elements.

A 32-bit control word selects the behaviour:

- the element width (8, 16 or 32 bits);
- whether elements are read as signed or unsigned;
- whether the operation covers one 64-bit register or two.

The control word also carries the register indices. The block checks them only for encodings that are not allowed. The block does not read or write a register file.

The caller presents the operand and control word together with a one-cycle strobe. One cycle later the block presents one of two outcomes:

- a registered result with a valid pulse, or
- an undefined-encoding pulse with a zeroed result.

The latency is the same for every data value.

Top module: `simd_pair_widen_add`

## Requirements
- R1: The element width is 8 << S, where S is the 2-bit field at control bits [19:18]. S = 3 is reserved and causes the undefined outcome.
- R2: Control bit 7 selects the element reading. With 0, each element is sign-extended before the add. With 1, each element is zero-extended.
- R3: Result lane i has twice the element width and equals element 2i plus element 2i+1, taken modulo the lane width. Element 0 and lane 0 sit at the least significant bits.
- R4: Control bit 6 selects the vector width. With 0, only source bits [63:0] are used and result bits [127:64] are zero. With 1, both 64-bit halves are used and pairs never cross the half boundary.
- R5: The destination index is {bit 22, bits [15:12]} and the source index is {bit 5, bits [3:0]}. When bit 6 is 1 and bit 12 or bit 0 is 1, the encoding is undefined. When bit 6 is 0, odd indices are legal.
- R6: In the undefined outcome, out_undef is 1, out_valid is 0 and res_vec is zero, all one cycle after the strobe.
- R7: out_valid and out_undef each pulse exactly one cycle after an in_valid strobe, and never without a strobe. Reset clears all outputs.
- R8: Without a strobe, res_vec keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Strobe: control word and operand are present |
| ctrl_word | input | 32 | Control word with size, signedness, width and register-index fields |
| src_vec | input | 128 | Source operand; only bits [63:0] are used in 64-bit mode |
| out_valid | output | 1 | Result valid pulse |
| out_undef | output | 1 | Undefined-encoding pulse |
| res_vec | output | 128 | Registered widened pairwise sums |

## Verification
Every outcome is due exactly one clock edge after the strobe that carries it: the result, the valid pulse and the undefined pulse alike. Cycles without a strobe are due one edge later as well, with both pulses low and the result held. The driver pushes one expected item for every cycle it drives, including idle cycles. The monitor pops one item shortly after each rising edge, so each comparison lines up with the cycle in which the registers have just taken their new value.

// File: rtl/spwa_pkg.sv
// Package: shared widths and control-word field positions for the pairwise
// widening adder. Assumes a 32-bit control word and 64-bit register halves.
package spwa_pkg;
    localparam int HALF_W   = 64;
    localparam int CTRL_W   = 32;
    localparam int SIZE_LO  = 18;
    localparam int UNS_BIT  = 7;
    localparam int QUAD_BIT = 6;
    localparam int DST_LSB  = 12;
    localparam int SRC_LSB  = 0;

    typedef struct packed {
        logic [1:0] size;
        logic       uns;
        logic       quad;
        logic       illegal;
    } spwa_ctrl_t;
endpackage

// File: rtl/spwa_decode.sv
// Decoder: pulls size, signedness and width out of the control word and
// flags the reserved size and odd register indices in quad mode.
// Assumes field positions from spwa_pkg; all other bits are ignored.
module spwa_decode
    import spwa_pkg::*;
(
    input  logic [CTRL_W-1:0] ctrl_word,
    output spwa_ctrl_t        dec
);
    logic dst_odd;
    logic src_odd;
    logic unused_ctrl_bits;

    // Field extraction and legality check.
    always_comb begin
        dec.size    = ctrl_word[SIZE_LO +: 2];
        dec.uns     = ctrl_word[UNS_BIT];
        dec.quad    = ctrl_word[QUAD_BIT];
        dst_odd     = ctrl_word[DST_LSB];
        src_odd     = ctrl_word[SRC_LSB];
        dec.illegal = (dec.size == 2'b11) || (dec.quad && (dst_odd || src_odd));
    end

    assign unused_ctrl_bits = ^{ctrl_word[CTRL_W-1:SIZE_LO+2], ctrl_word[SIZE_LO-1:DST_LSB+1],
                                ctrl_word[DST_LSB-1:UNS_BIT+1], ctrl_word[QUAD_BIT-1:SRC_LSB+1]};
endmodule

// File: rtl/spwa_half_adder.sv
// One 64-bit half: forms all three element-width variants of the pairwise
// widening sum in parallel, then selects one by size. Reserved size gives 0.
// The path is the same for all data values.
module spwa_half_adder #(
    parameter int HW = 64
) (
    input  logic [HW-1:0] half_in,
    input  logic [1:0]    size,
    input  logic          uns,
    output logic [HW-1:0] half_sum
);
    localparam int NUM_VAR = 3;

    logic [HW-1:0] var_sum [NUM_VAR];

    for (genvar k = 0; k < NUM_VAR; k++) begin : g_width
        localparam int ES = 8 << k;
        localparam int NP = HW / (2 * ES);
        for (genvar p = 0; p < NP; p++) begin : g_pair
            logic [ES-1:0]   e_lo;
            logic [ES-1:0]   e_hi;
            logic [2*ES-1:0] x_lo;
            logic [2*ES-1:0] x_hi;
            // Extend both elements of the pair to lane width and add them.
            always_comb begin
                e_lo = half_in[(2*p)*ES +: ES];
                e_hi = half_in[(2*p+1)*ES +: ES];
                x_lo = {{ES{~uns & e_lo[ES-1]}}, e_lo};
                x_hi = {{ES{~uns & e_hi[ES-1]}}, e_hi};
                var_sum[k][p*2*ES +: 2*ES] = x_lo + x_hi;
            end
        end
    end

    // Pick the variant that matches the element width.
    always_comb begin
        case (size)
            2'b00:   half_sum = var_sum[0];
            2'b01:   half_sum = var_sum[1];
            2'b10:   half_sum = var_sum[2];
            default: half_sum = '0;
        endcase
    end
endmodule

// File: rtl/simd_pair_widen_add.sv
// Top: decodes the control word, runs one half adder per 64-bit half, and
// registers the result with one cycle of latency. Assumes VEC_W is a
// multiple of 64. Half 0 is always active; upper halves only in quad mode.
module simd_pair_widen_add
    import spwa_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [CTRL_W-1:0] ctrl_word,
    input  logic [VEC_W-1:0]  src_vec,
    output logic              out_valid,
    output logic              out_undef,
    output logic [VEC_W-1:0]  res_vec
);
    localparam int NUM_HALF = VEC_W / HALF_W;

    spwa_ctrl_t       dec;
    logic [VEC_W-1:0] next_res;

    spwa_decode u_dec (
        .ctrl_word (ctrl_word),
        .dec       (dec)
    );

    for (genvar h = 0; h < NUM_HALF; h++) begin : g_half
        logic [HALF_W-1:0] hsum;
        spwa_half_adder #(.HW(HALF_W)) u_half (
            .half_in  (src_vec[h*HALF_W +: HALF_W]),
            .size     (dec.size),
            .uns      (dec.uns),
            .half_sum (hsum)
        );
        // Gate upper halves off unless the quad width is selected.
        always_comb begin
            next_res[h*HALF_W +: HALF_W] = (h == 0 || dec.quad) ? hsum : '0;
        end
    end

    // Output register: take a result or a zero on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_undef <= 1'b0;
            res_vec   <= '0;
        end else begin
            out_valid <= in_valid & ~dec.illegal;
            out_undef <= in_valid & dec.illegal;
            if (in_valid) begin
                res_vec <= dec.illegal ? '0 : next_res;
            end
        end
    end

    // R1
    size_rsv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && ctrl_word[SIZE_LO +: 2] == 2'b11 |=> out_undef && !out_valid);
    // R5
    odd_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && ctrl_word[QUAD_BIT] && (ctrl_word[DST_LSB] || ctrl_word[SRC_LSB]) |=> out_undef);
    // R6
    undef_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_undef |-> (res_vec == '0) && !out_valid);
    // R7
    strobe_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid || out_undef);
    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && !out_undef);
    // R8
    hold_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(res_vec));
    // R4
    narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !ctrl_word[QUAD_BIT] |=> res_vec[VEC_W-1:HALF_W] == '0);
endmodule

// File: tb/simd_pair_widen_add_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes one expected item per driven cycle,
// and the monitor pops and compares it just after the following rising edge.
module simd_pair_widen_add_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [31:0]  ctrl_word = '0;
    logic [127:0] src_vec = '0;
    wire          out_valid;
    wire          out_undef;
    wire  [127:0] res_vec;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    typedef struct {
        logic         v;
        logic         u;
        logic [127:0] r;
        string        tag;
    } exp_t;
    exp_t sb_q[$];
    logic [127:0] last_res = '0;

    always #2.5 clk = ~clk;

    simd_pair_widen_add u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ctrl_word(ctrl_word),
        .src_vec(src_vec), .out_valid(out_valid), .out_undef(out_undef), .res_vec(res_vec)
    );

    function automatic logic [31:0] mk_ctrl(input logic [1:0] sz, input logic uns, input logic q,
                                            input logic d, input logic [3:0] vd,
                                            input logic m, input logic [3:0] vm);
        logic [31:0] w;
        w = 32'hF380_0A10;
        w[19:18] = sz; w[7] = uns; w[6] = q; w[22] = d; w[15:12] = vd; w[5] = m; w[3:0] = vm;
        return w;
    endfunction

    // Reference model derived from R1-style field rules, written independently.
    function automatic logic [127:0] model(input logic [31:0] cw, input logic [127:0] s);
        logic [127:0] r;
        int es;
        logic [63:0] mk;
        r = '0;
        if (cw[19:18] == 2'b11) return r;
        es = 8 << cw[19:18];
        mk = (es == 32) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (2*es)) - 64'd1);
        for (int h = 0; h < (cw[6] ? 2 : 1); h++) begin
            for (int i = 0; i < 32/es; i++) begin
                longint a, b;
                logic [63:0] sm;
                a = longint'((s >> (h*64 + 2*i*es)) & ((128'd1 << es) - 1));
                b = longint'((s >> (h*64 + (2*i+1)*es)) & ((128'd1 << es) - 1));
                if (!cw[7] && a[es-1]) a = a - (longint'(1) << es);
                if (!cw[7] && b[es-1]) b = b - (longint'(1) << es);
                sm = 64'(a + b) & mk;
                r = r | (128'(sm) << (h*64 + i*2*es));
            end
        end
        return r;
    endfunction

    task automatic drive(input logic v, input logic [31:0] cw, input logic [127:0] s, input string tag);
        exp_t e;
        logic bad;
        @(negedge clk);
        in_valid = v; ctrl_word = cw; src_vec = s;
        bad = (cw[19:18] == 2'b11) || (cw[6] && (cw[12] || cw[0]));
        if (v) last_res = bad ? '0 : model(cw, s);
        e.v = v & ~bad; e.u = v & bad; e.r = last_res; e.tag = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: compare outputs with the oldest expected item after each edge.
    always @(posedge clk) begin
        #1;
        if (rst_n && sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_chk++;
            if (out_valid !== e.v || out_undef !== e.u || res_vec !== e.r) begin
                n_err++;
                $display("FAIL %s: got v=%b u=%b r=%h exp v=%b u=%b r=%h",
                         e.tag, out_valid, out_undef, res_vec, e.v, e.u, e.r);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: got hung run exp completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [127:0] pat;
        pat = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
        repeat (4) @(negedge clk);
        // R7: reset clears every output
        n_chk++;
        if (out_valid !== 1'b0 || out_undef !== 1'b0 || res_vec !== '0) begin
            n_err++;
            $display("FAIL R7 reset: got v=%b u=%b r=%h exp 0 0 0", out_valid, out_undef, res_vec);
        end
        rst_n = 1'b1;
        // R1 R2 R3: all widths, signed and unsigned, 64-bit mode
        drive(1, mk_ctrl(2'd0, 0, 0, 0, 4'd2, 0, 4'd4), pat, "R3 S8 d");
        drive(1, mk_ctrl(2'd0, 1, 0, 0, 4'd2, 0, 4'd4), pat, "R2 U8 d");
        drive(1, mk_ctrl(2'd1, 0, 0, 0, 4'd2, 0, 4'd4), pat, "R1 S16 d");
        drive(1, mk_ctrl(2'd1, 1, 0, 0, 4'd2, 0, 4'd4), pat, "R1 U16 d");
        drive(1, mk_ctrl(2'd2, 0, 0, 0, 4'd2, 0, 4'd4), pat, "R1 S32 d");
        drive(1, mk_ctrl(2'd2, 1, 0, 0, 4'd2, 0, 4'd4), pat, "R1 U32 d");
        // R2: extremes, all ones and most-negative values
        drive(1, mk_ctrl(2'd0, 0, 0, 0, 4'd0, 0, 4'd0), {64'h0, 64'hFFFF_FFFF_FFFF_FFFF}, "R2 S8 ones");
        drive(1, mk_ctrl(2'd0, 1, 0, 0, 4'd0, 0, 4'd0), {64'h0, 64'hFFFF_FFFF_FFFF_FFFF}, "R2 U8 ones");
        drive(1, mk_ctrl(2'd0, 0, 0, 0, 4'd0, 0, 4'd0), {64'h0, 64'h8080_8080_8080_8080}, "R2 S8 min");
        drive(1, mk_ctrl(2'd2, 0, 0, 0, 4'd0, 0, 4'd0), {64'h0, 64'h8000_0000_8000_0000}, "R2 S32 min");
        drive(1, mk_ctrl(2'd2, 1, 0, 0, 4'd0, 0, 4'd0), {64'h0, 64'hFFFF_FFFF_FFFF_FFFF}, "R2 U32 ones");
        // R4: 64-bit mode ignores the upper source half
        drive(1, mk_ctrl(2'd1, 0, 0, 0, 4'd0, 0, 4'd0), {64'hFFFF_FFFF_FFFF_FFFF, 64'h1}, "R4 upper zero");
        // R4: 128-bit mode, halves paired independently
        drive(1, mk_ctrl(2'd0, 0, 1, 1, 4'd2, 1, 4'd6), pat, "R4 S8 q");
        drive(1, mk_ctrl(2'd1, 1, 1, 0, 4'd4, 0, 4'd8), pat, "R4 U16 q");
        drive(1, mk_ctrl(2'd2, 0, 1, 0, 4'd4, 0, 4'd8), {64'h7FFF_FFFF_0000_0001, 64'hFFFF_FFFF_0000_0001}, "R4 S32 q");
        // R1 R6: reserved size gives the undefined outcome
        drive(1, mk_ctrl(2'd3, 0, 0, 0, 4'd2, 0, 4'd4), pat, "R1 size rsv");
        drive(1, mk_ctrl(2'd3, 1, 1, 0, 4'd2, 0, 4'd4), pat, "R6 size rsv q");
        // R5: odd indices in quad mode are undefined; D/M high bits do not matter
        drive(1, mk_ctrl(2'd0, 0, 1, 0, 4'd3, 0, 4'd4), pat, "R5 odd dst");
        drive(1, mk_ctrl(2'd0, 0, 1, 0, 4'd2, 0, 4'd5), pat, "R5 odd src");
        drive(1, mk_ctrl(2'd0, 0, 0, 1, 4'd3, 1, 4'd5), pat, "R5 odd d legal");
        drive(1, mk_ctrl(2'd1, 0, 1, 1, 4'd0, 1, 4'd0), pat, "R5 high bits legal");
        // R8 R7: idle cycles hold the result and raise no pulse
        drive(0, mk_ctrl(2'd3, 0, 1, 0, 4'd1, 0, 4'd1), ~pat, "R8 idle hold");
        drive(0, mk_ctrl(2'd0, 1, 0, 0, 4'd0, 0, 4'd0), pat, "R7 idle quiet");
        drive(1, mk_ctrl(2'd0, 1, 1, 0, 4'd0, 0, 4'd0), ~pat, "R7 after gap");
        drive(1, mk_ctrl(2'd3, 1, 1, 0, 4'd0, 0, 4'd0), ~pat, "R6 clears");
        drive(0, '0, '0, "R8 hold zero");
        drive(0, '0, '0, "R7 idle end");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule